// File: doc/BRIEF.md
# Memory Port Read Output Stage

This block is the last stage of the read path of one memory port. Each cycle it takes the word the storage array returns for the address captured at the most recent clock edge. It also takes the port's chip-enable pair, per-byte lane selects, write flag and output enable. From these it produces the port's data word and one drive flag per byte lane. A pad ring or bus mux uses those flags to decide which lanes actually drive.

A static mode input picks between two timings. In flow-through mode the array word goes straight to the output in the cycle it is read. In pipelined mode an extra output register adds one cycle of latency, and the chip-enable state is delayed by a second register to match. The byte lane selects stay one register deep in both modes. The output enable acts asynchronously, after every register.

The pipelined output register can be frozen when the port's address neither loads nor advances, so the data on the output does not change on later clocks. The mode input is meant to be tied or set before reset and left alone during operation.

Top module: `rdo_out_stage`

## Requirements
- R1: While reset is held, and directly after it, no lane drive flag is set, and in pipelined mode the data output reads zero.
- R2: With `pipe_mode` = 0 (flow-through), `dout` equals `rd_data` in the same cycle. The lane drive flags follow the controls sampled at the most recent rising edge.
- R3: With `pipe_mode` = 1 (pipelined), `dout` equals the value `rd_data` held at the previous rising edge, which is one cycle later than in flow-through.
- R4: `lane_sel_n[0]` covers data bits 7:0 and `lane_sel_n[1]` covers bits 15:8. Both are active low and registered once in either mode. A lane whose select was high at the most recent edge is not driven.
- R5: The port is enabled when `cs_n` = 0 and `cs` = 1. In flow-through mode this state is registered once, so a disabled state sampled at an edge turns all lanes off right after that edge.
- R6: In pipelined mode the enable state passes two registers. A disable sampled at edge k turns the lanes off only after edge k+1. A re-enable sampled at edge k lets them drive again only after edge k+1.
- R7: A write cycle (`wr` = 1) leaves every lane undriven, even with the output enable active. This takes effect after the same edge in flow-through mode, and one edge later in pipelined mode.
- R8: `oe_n` = 1 clears every lane drive flag at once, with no clock edge needed. Returning it to 0 restores the flags held by the registers.
- R9: In pipelined mode, `addr_hold` = 1 at an edge keeps the output data register unchanged across that edge, even if `rd_data` changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static mode: 0 flow-through, 1 pipelined |
| cs_n | input | 1 | Active-low chip enable |
| cs | input | 1 | Active-high chip enable |
| lane_sel_n | input | 2 | Active-low byte lane selects, bit 0 for low byte |
| wr | input | 1 | Cycle is a write when high |
| addr_hold | input | 1 | Address neither loaded nor advanced this edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rd_data | input | 16 | Word read from the array for the current address |
| dout | output | 16 | Output data word |
| lane_drv | output | 2 | Per-lane drive flags, bit 0 for low byte |

## Verification
The embedded properties check, on every cycle, that an inactive output enable, a deselected lane, a disabled chip enable or a write cycle produces no drive flag. Each is checked at the cycle offset its mode dictates: one edge for flow-through and two for pipelined enable and write state. They also check that a held address freezes the pipelined data. Only the bench scenarios show that data arrives with the correct latency in each mode, and that a lane turns back on exactly when it should after a deselect or a write. The scenarios also show the mixed timing in pipelined mode, where the lane selects lead the data by a cycle, and that an output-enable change takes effect between edges.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   localparam int unsigned RDO_LANE_W_DEF = 8;
   localparam int unsigned RDO_LANES_DEF  = 2;

   typedef enum logic {
      RDO_FLOW = 1'b0,
      RDO_PIPE = 1'b1
   } rdo_mode_e;

   function automatic logic rdo_enabled(input logic act_lo, input logic act_hi);
      return (!act_lo) && act_hi;
   endfunction
endpackage

// File: rtl/rdo_ctl_reg.sv
module rdo_ctl_reg #(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_in,
   input  logic             rd_in,
   input  logic [LANES-1:0] lane_in,
   output logic             en_q1,
   output logic             en_q2,
   output logic             rd_q1,
   output logic             rd_q2,
   output logic [LANES-1:0] lane_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q1  <= 1'b0;
         en_q2  <= 1'b0;
         rd_q1  <= 1'b0;
         rd_q2  <= 1'b0;
         lane_q <= '0;
      end else begin
         en_q1  <= en_in;
         en_q2  <= en_q1;
         rd_q1  <= rd_in;
         rd_q2  <= rd_q1;
         lane_q <= lane_in;
      end
   end

   // R6: second enable stage lags the first by exactly one edge
   assert_en_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q1) |-> en_q2);
endmodule

// File: rtl/rdo_data_reg.sv
module rdo_data_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     d_q <= '0;
      else if (!hold) d_q <= d_in;
   end

   // R9: a held edge leaves the register unchanged
   assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold) |-> $stable(d_q));
endmodule

// File: rtl/rdo_lane_gate.sv
module rdo_lane_gate #(
   parameter int unsigned LANES = 2
) (
   input  logic             port_on,
   input  logic             oe_n,
   input  logic [LANES-1:0] lane_q,
   output logic [LANES-1:0] drv
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign drv[i] = port_on && lane_q[i] && !oe_n;
   end
endmodule

// File: rtl/rdo_out_stage.sv
module rdo_out_stage
   import rdo_pkg::*;
#(
   parameter int unsigned LANE_W = RDO_LANE_W_DEF,
   parameter int unsigned LANES  = RDO_LANES_DEF,
   localparam int unsigned DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              cs_n,
   input  logic              cs,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              wr,
   input  logic              addr_hold,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  lane_drv
);
   if (LANE_W < 1) begin : g_bad_w
      $error("rdo_out_stage: LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_l
      $error("rdo_out_stage: LANES must be at least 1");
   end

   logic             en_now;
   logic             en_q1, en_q2, rd_q1, rd_q2;
   logic [LANES-1:0] lane_q;
   logic [DATA_W-1:0] pipe_q;
   logic             port_on;
   rdo_mode_e        mode;

   assign mode   = rdo_mode_e'(pipe_mode);
   assign en_now = rdo_enabled(cs_n, cs);

   rdo_ctl_reg #(.LANES(LANES)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_in  (en_now),
      .rd_in  (!wr),
      .lane_in(~lane_sel_n),
      .en_q1  (en_q1),
      .en_q2  (en_q2),
      .rd_q1  (rd_q1),
      .rd_q2  (rd_q2),
      .lane_q (lane_q)
   );

   rdo_data_reg #(.DATA_W(DATA_W)) u_data (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (addr_hold),
      .d_in (rd_data),
      .d_q  (pipe_q)
   );

   always_comb begin
      if (mode == RDO_PIPE) begin
         port_on = en_q2 && rd_q2;
         dout    = pipe_q;
      end else begin
         port_on = en_q1 && rd_q1;
         dout    = rd_data;
      end
   end

   rdo_lane_gate #(.LANES(LANES)) u_gate (
      .port_on(port_on),
      .oe_n   (oe_n),
      .lane_q (lane_q),
      .drv    (lane_drv)
   );

   assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (lane_drv == '0));

   assert_flow_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(!en_now)) |-> (lane_drv == '0));

   assert_pipe_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(!en_now, 2)) |-> (lane_drv == '0));

   assert_flow_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(wr)) |-> (lane_drv == '0));

   assert_pipe_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(wr, 2)) |-> (lane_drv == '0));

   assert_pipe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(addr_hold)) |-> $stable(dout));

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      assert_lane_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(lane_sel_n[i]) |-> !lane_drv[i]);
   end
endmodule

// File: tb/tb_rdo_out_stage.sv
`timescale 1ns/1ps
module tb_rdo_out_stage;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pipe_mode = 1'b0;
   logic        cs_n = 1'b1, cs = 1'b0, wr = 1'b0, addr_hold = 1'b0, oe_n = 1'b1;
   logic [1:0]  lane_sel_n = 2'b11;
   logic [15:0] rd_data = 16'h0;
   logic [15:0] dout;
   logic [1:0]  lane_drv;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rdo_out_stage dut (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs_n(cs_n), .cs(cs),
      .lane_sel_n(lane_sel_n), .wr(wr), .addr_hold(addr_hold), .oe_n(oe_n),
      .rd_data(rd_data), .dout(dout), .lane_drv(lane_drv)
   );

   // {mode, cs_n, cs, lane_sel_n[1:0], wr, hold, oe_n, rd_data[15:0]}
   localparam int NV = 26;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h1234},
      {1'b0,1'b0,1'b1,2'b10,1'b0,1'b0,1'b0,16'hA5C3},
      {1'b0,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,16'h0F0F},
      {1'b0,1'b0,1'b1,2'b00,1'b1,1'b0,1'b0,16'h7777},
      {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h8001},
      {1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,16'h2222},
      {1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,16'h3333},
      {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h4444},
      {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b1,16'h5555},
      {1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,1'b0,16'h6666},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h1111},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'hBEEF},
      {1'b1,1'b0,1'b1,2'b10,1'b0,1'b0,1'b0,16'hCAFE},
      {1'b1,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,16'hD00D},
      {1'b1,1'b0,1'b1,2'b00,1'b1,1'b0,1'b0,16'h9999},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'hABCD},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h1357},
      {1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,16'h2468},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h3579},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h4680},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,16'hF00F},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,16'h0FF0},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h5A5A},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b1,16'h6B6B},
      {1'b1,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,16'h7C7C},
      {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h8D8D}
   };

   // bench-side reference state, built from the requirements
   logic       m_en1, m_en2, m_rd1, m_rd2;
   logic [1:0] m_lane;
   logic [15:0] m_pd;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_en1 = 0; m_en2 = 0; m_rd1 = 0; m_rd2 = 0; m_lane = 0; m_pd = 0;
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0;
      pipe_mode = mode;
      cs_n = 1'b1; cs = 1'b0; lane_sel_n = 2'b11; wr = 1'b0; addr_hold = 1'b0;
      oe_n = 1'b0; rd_data = 16'hFACE;
      model_reset();
      @(negedge clk);
      check("R1 reset lanes", {30'd0, lane_drv}, 32'd0);
      if (mode) check("R1 reset pipe data", {16'd0, dout}, 32'd0);
      rst_n = 1'b1;
   endtask

   function automatic logic [1:0] exp_drv();
      logic on;
      on = pipe_mode ? (m_en2 && m_rd2) : (m_en1 && m_rd1);
      return (on && !oe_n) ? m_lane : 2'b00;
   endfunction

   task automatic step(input logic [23:0] v, input string tag);
      @(negedge clk);
      {pipe_mode, cs_n, cs, lane_sel_n, wr, addr_hold, oe_n, rd_data} = v;
      @(posedge clk);
      m_en2 = m_en1;
      m_rd2 = m_rd1;
      m_en1 = !cs_n && cs;
      m_rd1 = !wr;
      m_lane = ~lane_sel_n;
      if (!addr_hold) m_pd = rd_data;
      #2;
      check({tag, " drive"}, {30'd0, lane_drv}, {30'd0, exp_drv()});
      check({tag, " data"}, {16'd0, dout}, {16'd0, pipe_mode ? m_pd : rd_data});
   endtask

   initial begin
      model_reset();
      do_reset(1'b0);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][23] != pipe_mode) do_reset(VEC[i][23]);
         step(VEC[i], VEC[i][23] ? "R3 R4 R6 R7 R8 R9" : "R2 R4 R5 R7 R8");
      end

      // R8: output enable acts between edges
      do_reset(1'b0);
      step({1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h1212}, "R2");
      #1 oe_n = 1'b1;
      #0.5 check("R8 oe off mid-cycle", {30'd0, lane_drv}, 32'd0);
      oe_n = 1'b0;
      #0.5 check("R8 oe back on", {30'd0, lane_drv}, 32'd3);

      // R6: single-edge deselect in pipelined mode, cycle-by-cycle
      do_reset(1'b1);
      step({1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h0001}, "R6");
      step({1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h0002}, "R6");
      check("R6 on before deselect", {30'd0, lane_drv}, 32'd3);
      step({1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,16'h0003}, "R6");
      check("R6 still on one edge after deselect", {30'd0, lane_drv}, 32'd3);
      step({1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h0004}, "R6");
      check("R6 off two edges after deselect", {30'd0, lane_drv}, 32'd0);
      step({1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,16'h0005}, "R6");
      check("R6 back on", {30'd0, lane_drv}, 32'd3);
      check("R3 latency", {16'd0, dout}, 32'h0005);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule